// File: doc/BRIEF.md
# Miss-Dependent Dispatch Hold Unit

This unit sits between register renaming and the shared issue queue of a core that runs two redundant copies of a program: a leading thread and a trailing thread. Each cycle it looks at one renamed candidate instruction. It decides whether that candidate may take an issue-queue entry now. The alternative is to park it, because the candidate reads a value that will come from a leading-thread load that missed the data cache.

The unit keeps one "poisoned" bit per physical register. A miss report from a leading-thread load poisons the load's destination tag. A leading-thread candidate that reads a poisoned tag is parked in an in-order hold buffer, and its own destination becomes poisoned as well. Anything that reads that destination is therefore also held, however long the chain.

When the next memory level returns the missing value, a fill report clears the tag. Parked instructions then leave from a separate release port, oldest first. Releasing an entry clears the poison on its destination. Trailing-thread instructions get their load values from the leading thread, so the hold never applies to them. A flush empties the buffer and forgets all poison.

Top module: `mdh_dispatch_hold`

## Requirements
- R1: A valid candidate with thread id 1 (trailing) raises `disp_en` and never raises `cand_stall` or `hold_take`, whatever the poison state or buffer fill level.
- R2: A valid candidate with thread id 0 (leading) whose two source tags are both unpoisoned raises `disp_en` in the same cycle, even while older instructions sit in the hold buffer.
- R3: A valid leading candidate with either source tag poisoned raises `hold_take` and not `disp_en` when the buffer has room. Its destination tag is poisoned from the next cycle, so later readers of that tag are held too.
- R4: A miss report with thread id 0 poisons its tag from the following cycle. A miss report with thread id 1 has no effect.
- R5: A fill report clears the poison of its tag. If the oldest held entry then has both sources clear, `rel_valid` is high in the cycle after the fill, presenting that entry's tags.
- R6: Held entries leave through the release port in the order they were captured, at most one per cycle. Releasing an entry clears the poison on its destination tag.
- R7: The hold buffer holds 8 entries. When it is full, a leading candidate that needs holding gets `cand_stall` high with `disp_en` and `hold_take` low, and it is not captured.
- R8: While `flush` is high, `disp_en`, `hold_take`, `cand_stall` and `rel_valid` are low. From the next cycle the buffer is empty and every tag is unpoisoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the hold buffer and clear all poison |
| cand_valid | input | 1 | Renamed candidate present this cycle |
| cand_tid | input | 1 | Candidate thread: 0 leading, 1 trailing |
| cand_src0 | input | 6 | First physical source tag |
| cand_src1 | input | 6 | Second physical source tag |
| cand_dst | input | 6 | Physical destination tag |
| miss_valid | input | 1 | A load missed the data cache |
| miss_tid | input | 1 | Thread of the missing load |
| miss_tag | input | 6 | Destination tag of the missing load |
| fill_valid | input | 1 | Missing data returned from the next level |
| fill_tag | input | 6 | Tag whose data returned |
| disp_en | output | 1 | Candidate may take an issue-queue entry now |
| hold_take | output | 1 | Candidate captured into the hold buffer |
| cand_stall | output | 1 | Candidate refused; present it again |
| rel_valid | output | 1 | Oldest held entry goes to the issue queue |
| rel_src0 | output | 6 | First source tag of the released entry |
| rel_src1 | output | 6 | Second source tag of the released entry |
| rel_dst | output | 6 | Destination tag of the released entry |

## Verification
Suppose a poison bit is wrongly set or left standing. In the same cycle, an independent leading candidate that reads it shows `hold_take` instead of `disp_en`. A released chain also stops at the port, because `rel_valid` never rises for the entry behind it. A bit wrongly cleared shows up one cycle after the fill or release that touched it, as a release before its fill or an early `disp_en`. Bad buffer pointers or count show up as releases whose destination tags come out of order or duplicated, or as a stall at the wrong depth.

// File: rtl/mdh_pkg.sv
package mdh_pkg;
  localparam logic LEAD_TID = 1'b0;

  // A candidate is held only if it belongs to the leading thread
  // and at least one of its operands is still waiting on a miss.
  function automatic logic needs_hold(input logic tid, input logic p0, input logic p1);
    return (tid == LEAD_TID) && (p0 || p1);
  endfunction

  // Pointer advance with wrap at an arbitrary depth.
  function automatic int unsigned wrap_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/mdh_poison_table.sv
module mdh_poison_table #(
  parameter int TAG_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  set0_en,
  input  logic [TAG_W-1:0]      set0_tag,
  input  logic                  set1_en,
  input  logic [TAG_W-1:0]      set1_tag,
  input  logic                  clr0_en,
  input  logic [TAG_W-1:0]      clr0_tag,
  input  logic                  clr1_en,
  input  logic [TAG_W-1:0]      clr1_tag,
  input  logic [3:0][TAG_W-1:0] rd_tag,
  output logic [3:0]            rd_bit
);
  localparam int NREG = 1 << TAG_W;

  logic [NREG-1:0] pois_q;

  for (genvar g = 0; g < NREG; g++) begin : g_bit
    logic set_hit, clr_hit;
    assign set_hit = (set0_en && set0_tag == TAG_W'(g)) || (set1_en && set1_tag == TAG_W'(g));
    assign clr_hit = (clr0_en && clr0_tag == TAG_W'(g)) || (clr1_en && clr1_tag == TAG_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || flush) pois_q[g] <= 1'b0;
      else if (set_hit)    pois_q[g] <= 1'b1;
      else if (clr_hit)    pois_q[g] <= 1'b0;
    end
  end

  for (genvar r = 0; r < 4; r++) begin : g_rd
    assign rd_bit[r] = pois_q[rd_tag[r]];
  end

  // R4
  miss_poisons_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set1_en && !flush) |=> pois_q[$past(set1_tag)]);

  // R5
  fill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0_en && !flush && !(set0_en && set0_tag == clr0_tag) && !(set1_en && set1_tag == clr0_tag))
      |=> !pois_q[$past(clr0_tag)]);

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pois_q == '0));
endmodule

// File: rtl/mdh_hold_fifo.sv
module mdh_hold_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  import mdh_pkg::*;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= PW'(wrap_next(32'(wp), DEPTH));
      if (rd_en) rp <= PW'(wrap_next(32'(rp), DEPTH));
      cnt <= cnt + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/mdh_dispatch_hold.sv
module mdh_dispatch_hold #(
  parameter int TAG_W      = 6,
  parameter int HOLD_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cand_valid,
  input  logic             cand_tid,
  input  logic [TAG_W-1:0] cand_src0,
  input  logic [TAG_W-1:0] cand_src1,
  input  logic [TAG_W-1:0] cand_dst,
  input  logic             miss_valid,
  input  logic             miss_tid,
  input  logic [TAG_W-1:0] miss_tag,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             disp_en,
  output logic             hold_take,
  output logic             cand_stall,
  output logic             rel_valid,
  output logic [TAG_W-1:0] rel_src0,
  output logic [TAG_W-1:0] rel_src1,
  output logic [TAG_W-1:0] rel_dst
);
  import mdh_pkg::*;
  localparam int ENT_W = 3 * TAG_W;

  logic [3:0][TAG_W-1:0] rd_tag;
  logic [3:0]            rd_bit;
  logic [ENT_W-1:0]      head;
  logic                  buf_empty, buf_full;

  // Named internal events
  logic live, cand_dep, head_ready, lead_miss;

  assign {rel_src0, rel_src1, rel_dst} = head;

  assign rd_tag = {rel_src1, rel_src0, cand_src1, cand_src0};

  assign live       = cand_valid && !flush;
  assign cand_dep   = needs_hold(cand_tid, rd_bit[0], rd_bit[1]);
  assign head_ready = !buf_empty && !rd_bit[2] && !rd_bit[3];
  assign lead_miss  = miss_valid && (miss_tid == LEAD_TID);

  assign disp_en    = live && !cand_dep;
  assign hold_take  = live && cand_dep && !buf_full;
  assign cand_stall = live && cand_dep && buf_full;
  assign rel_valid  = !flush && head_ready;

  mdh_poison_table #(.TAG_W(TAG_W)) u_pois (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .set0_en  (hold_take),
    .set0_tag (cand_dst),
    .set1_en  (lead_miss),
    .set1_tag (miss_tag),
    .clr0_en  (fill_valid),
    .clr0_tag (fill_tag),
    .clr1_en  (rel_valid),
    .clr1_tag (rel_dst),
    .rd_tag   (rd_tag),
    .rd_bit   (rd_bit)
  );

  mdh_hold_fifo #(.W(ENT_W), .DEPTH(HOLD_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_en   (hold_take),
    .wr_data ({cand_src0, cand_src1, cand_dst}),
    .rd_en   (rel_valid),
    .rd_data (head),
    .empty   (buf_empty),
    .full    (buf_full)
  );

  // R1
  trail_never_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_tid != LEAD_TID && !flush) |-> (disp_en && !cand_stall && !hold_take));

  // R6
  release_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (!rd_bit[2] && !rd_bit[3]));

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !(disp_en || hold_take || cand_stall || rel_valid));
endmodule

// File: tb/test_mdh_dispatch_hold.sv
`timescale 1ns/1ps
module test_mdh_dispatch_hold;
  logic       clk = 1'b0;
  logic       rst_n, flush;
  logic       cand_valid, cand_tid;
  logic [5:0] cand_src0, cand_src1, cand_dst;
  logic       miss_valid, miss_tid;
  logic [5:0] miss_tag;
  logic       fill_valid;
  logic [5:0] fill_tag;
  logic       disp_en, hold_take, cand_stall, rel_valid;
  logic [5:0] rel_src0, rel_src1, rel_dst;

  int n_cmp = 0;
  int n_bad = 0;
  bit armed = 1'b0;
  logic [5:0] exp_q[$];

  always #10 clk = ~clk;

  mdh_dispatch_hold i_mdh_dispatch_hold (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cand_valid(cand_valid), .cand_tid(cand_tid),
    .cand_src0(cand_src0), .cand_src1(cand_src1), .cand_dst(cand_dst),
    .miss_valid(miss_valid), .miss_tid(miss_tid), .miss_tag(miss_tag),
    .fill_valid(fill_valid), .fill_tag(fill_tag),
    .disp_en(disp_en), .hold_take(hold_take), .cand_stall(cand_stall),
    .rel_valid(rel_valid), .rel_src0(rel_src0), .rel_src1(rel_src1), .rel_dst(rel_dst)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance to the next cycle and return every input to idle.
  task automatic nxt();
    @(negedge clk);
    cand_valid = 1'b0; miss_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic cand(input logic tid, input logic [5:0] s0, input logic [5:0] s1, input logic [5:0] d);
    cand_valid = 1'b1; cand_tid = tid; cand_src0 = s0; cand_src1 = s1; cand_dst = d;
  endtask

  // Check the three dispatch outcomes after inputs settle.
  task automatic expect_out(input string req, input logic de, input logic ht, input logic st);
    #5;
    chk({req, " disp_en"}, 6'(disp_en), 6'(de));
    chk({req, " hold_take"}, 6'(hold_take), 6'(ht));
    chk({req, " cand_stall"}, 6'(cand_stall), 6'(st));
  endtask

  task automatic drain(input int limit);
    armed = 1'b1;
    for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
    armed = 1'b0;
    chk("R6 all held entries released", 6'(exp_q.size()), 6'd0);
  endtask

  // Monitor: compare each release against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #6;
      if (rst_n && rel_valid) begin
        n_cmp++;
        if (!armed) begin
          n_bad++;
          $display("FAIL R5 release before fill: actual dst %0d expected none", rel_dst);
        end else if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R6 extra release: actual dst %0d expected none", rel_dst);
        end else begin
          logic [5:0] e;
          e = exp_q.pop_front();
          if (rel_dst !== e) begin
            n_bad++;
            $display("FAIL R6 release order: actual dst %0d expected %0d", rel_dst, e);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; cand_valid = 1'b0; cand_tid = 1'b0;
    cand_src0 = '0; cand_src1 = '0; cand_dst = '0;
    miss_valid = 1'b0; miss_tid = 1'b0; miss_tag = '0;
    fill_valid = 1'b0; fill_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R8 reset rel_valid", 6'(rel_valid), 6'd0);
    chk("R8 reset disp_en", 6'(disp_en), 6'd0);

    // R2: independent leading instruction dispatches.
    nxt(); cand(1'b0, 6'd1, 6'd2, 6'd3); expect_out("R2 independent lead", 1, 0, 0);

    // R4: leading miss on tag 10.
    nxt(); miss_valid = 1'b1; miss_tid = 1'b0; miss_tag = 6'd10;
    // R3: direct dependent held.
    nxt(); cand(1'b0, 6'd4, 6'd10, 6'd11); expect_out("R3 R4 direct dependent", 0, 1, 0);
    exp_q.push_back(6'd11);
    // R3: transitive dependent held.
    nxt(); cand(1'b0, 6'd11, 6'd5, 6'd12); expect_out("R3 chained dependent", 0, 1, 0);
    exp_q.push_back(6'd12);
    // R1: trailing reader of the poisoned tag dispatches.
    nxt(); cand(1'b1, 6'd10, 6'd11, 6'd13); expect_out("R1 trailing on poisoned", 1, 0, 0);
    // R2: independent leading bypasses non-empty buffer.
    nxt(); cand(1'b0, 6'd5, 6'd6, 6'd14); expect_out("R2 bypass held", 1, 0, 0);
    // Unrelated fill must not release anything.
    nxt(); fill_valid = 1'b1; fill_tag = 6'd33;
    nxt(); #5; chk("R5 unrelated fill no release", 6'(rel_valid), 6'd0);

    // R5: fill 10, head released the following cycle.
    nxt(); fill_valid = 1'b1; fill_tag = 6'd10; armed = 1'b1;
    nxt(); #5;
    chk("R5 release after fill", 6'(rel_valid), 6'd1);
    chk("R5 released src1", rel_src1, 6'd10);
    drain(20);
    // R6: released destination no longer poisoned.
    nxt(); cand(1'b0, 6'd11, 6'd12, 6'd15); expect_out("R6 release clears dst", 1, 0, 0);

    // R4: trailing miss report ignored.
    nxt(); miss_valid = 1'b1; miss_tid = 1'b1; miss_tag = 6'd50;
    nxt(); cand(1'b0, 6'd50, 6'd1, 6'd51); expect_out("R4 trailing miss ignored", 1, 0, 0);

    // R7: fill the 8-entry buffer.
    nxt(); miss_valid = 1'b1; miss_tid = 1'b0; miss_tag = 6'd20;
    for (int i = 0; i < 8; i++) begin
      nxt(); cand(1'b0, 6'd20, 6'd2, 6'(30 + i)); expect_out("R7 filling buffer", 0, 1, 0);
      exp_q.push_back(6'(30 + i));
    end
    nxt(); cand(1'b0, 6'd20, 6'd3, 6'd40); expect_out("R7 full stalls lead", 0, 0, 1);
    nxt(); cand(1'b1, 6'd20, 6'd3, 6'd41); expect_out("R1 trailing while full", 1, 0, 0);
    nxt(); fill_valid = 1'b1; fill_tag = 6'd20; armed = 1'b1;
    drain(30);

    // R8: flush discards held entry and poison.
    nxt(); miss_valid = 1'b1; miss_tid = 1'b0; miss_tag = 6'd42;
    nxt(); cand(1'b0, 6'd42, 6'd1, 6'd43); expect_out("R8 setup hold", 0, 1, 0);
    nxt(); flush = 1'b1; cand(1'b0, 6'd43, 6'd1, 6'd44); expect_out("R8 flush cycle quiet", 0, 0, 0);
    nxt(); cand(1'b0, 6'd42, 6'd1, 6'd45); expect_out("R8 miss poison cleared", 1, 0, 0);
    nxt(); cand(1'b0, 6'd43, 6'd1, 6'd46); expect_out("R8 held dst cleared", 1, 0, 0);
    nxt(); fill_valid = 1'b1; fill_tag = 6'd42;
    repeat (3) nxt();
    #5; chk("R8 buffer empty after flush", 6'(rel_valid), 6'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule